// File: doc/BRIEF.md
# Pixel to Video Memory Address Generator

This block turns a pixel coordinate into a byte address in video memory for a 2D drawing engine. A drawing engine offers an (x, y) pair through a ready/valid request port. The block works out the pixel's linear index from the selected row stride, scales it by the pixel depth and places a programmable 12-bit offset above the 20-bit pixel byte offset. Alongside the address it reports which byte lane of the memory bus word the pixel starts on and, for depths below one byte, the bit position of the pixel inside that byte.

Power-of-two row strides (256, 512, 1024 or 2048 pixels) use fixed shifts and give one result per cycle. A 320-pixel stride is also available at 8 bits per pixel. It builds y×320 from two shifted terms over two sequential add cycles, and ready stays low while that runs. A coordinate that does not fit the selected row raises an out-of-range strobe in place of an address. A configuration port, sampled on a write strobe, holds the stride, the 320 mode enable, the depth, the bus width and the offset.

Top module: `pix_addr_gen`

## Requirements
- R1: After reset, ready is 1, out_valid and out_oor are 0, and the configuration is stride 256, 8 bpp, 32-bit bus, offset 0, 320 mode off.
- R2: With 320 mode not in effect, row_sel codes 0/1/2/3 select strides 256/512/1024/2048. The pixel index is y×stride+x. The result appears with out_valid=1 in the cycle after acceptance, and ready stays 1, so requests can be accepted back to back.
- R3: When 320 mode is enabled and the depth code is 3 (8 bpp), the index is y×320+x. The result appears two cycles after the cycle that follows acceptance, and ready is 0 and out_valid is 0 in the two cycles in between. At any other depth the 320 enable has no effect.
- R4: Depth codes 0..5 mean 1, 2, 4, 8, 16 and 24 bpp. The byte offset is floor(index×bpp/8), and out_addr[19:0] holds its low 20 bits.
- R5: out_addr[31:20] equals the programmed 12-bit offset.
- R6: Bus code 0 means 8 bits, 1 means 16 bits, 2 and 3 mean 32 bits. out_lane is 0 on an 8-bit bus, bit 0 of the byte offset on a 16-bit bus, and bits 1:0 of the byte offset on a 32-bit bus.
- R7: out_bit is (index×bpp) mod 8 for 1, 2 and 4 bpp, and 0 otherwise.
- R8: If x is not below the active stride (320 in 320 mode), out_oor is 1 for one cycle in the cycle after acceptance and no out_valid follows for that request. This also holds in 320 mode.
- R9: A request is accepted only at a clock edge where req_valid and ready are both 1. A request held while ready is 0 produces no result.
- R10: A configuration write takes effect for requests accepted at later edges. A request accepted at the same edge as a write uses the earlier configuration.
- R11: Reserved depth codes 6 and 7 scale like 8 bpp, but they do not enable the 320 stride.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_row_sel | input | 2 | Power-of-two stride code |
| cfg_row320 | input | 1 | 320-pixel stride enable |
| cfg_bpp_sel | input | 3 | Pixel depth code |
| cfg_bus_sel | input | 2 | Memory bus width code |
| cfg_base | input | 12 | High-order address offset |
| req_valid | input | 1 | Coordinate request valid |
| req_x | input | 11 | Column coordinate |
| req_y | input | 11 | Row coordinate |
| req_ready | output | 1 | Request can be accepted |
| out_valid | output | 1 | Address result strobe |
| out_oor | output | 1 | Out-of-range strobe |
| out_addr | output | 32 | Byte address (0 when out_valid is 0) |
| out_lane | output | 2 | Starting byte lane in the bus word |
| out_bit | output | 3 | Bit position within the byte |

## Verification
A configuration write and a request acceptance can fall in the same clock edge. This is provoked by driving cfg_we together with a request that switches the block from 320 mode to a power-of-two stride at 16 bpp with a new offset. The result is judged by checking that this request still takes the two-cycle 320 path and carries the old offset. The next request must then reflect the new stride, depth and offset. A 320-mode computation that overlaps a request held during its busy cycles is judged the same way: exactly one result, for the first coordinate.

// File: rtl/pag_pkg.sv
// Package: shared encodings and configuration types for the pixel address
// generator. Assumes a 12-bit high-order offset and at most a 32-bit bus.
package pag_pkg;

    localparam int PAG_BASE_W = 12;

    localparam logic [2:0] BPP_1  = 3'd0;
    localparam logic [2:0] BPP_2  = 3'd1;
    localparam logic [2:0] BPP_4  = 3'd2;
    localparam logic [2:0] BPP_8  = 3'd3;
    localparam logic [2:0] BPP_16 = 3'd4;
    localparam logic [2:0] BPP_24 = 3'd5;

    localparam logic [1:0] BUS_8  = 2'd0;
    localparam logic [1:0] BUS_16 = 2'd1;
    localparam logic [1:0] BUS_32 = 2'd2;

    // Fields the address formatter needs, snapshotted per request
    typedef struct packed {
        logic [2:0]            bpp;
        logic [1:0]            bus;
        logic [PAG_BASE_W-1:0] base;
    } pag_fmt_cfg_t;

    // Full configuration held by the register stage
    typedef struct packed {
        logic [1:0]   row;
        logic         m320;
        pag_fmt_cfg_t fmt;
    } pag_cfg_t;

    localparam pag_cfg_t PAG_CFG_RESET = '{
        row:  2'd0,
        m320: 1'b0,
        fmt:  '{bpp: BPP_8, bus: BUS_32, base: '0}
    };

endpackage

// File: rtl/pag_cfg_regs.sv
// Module: pag_cfg_regs
// Holds the stride, 320 mode, depth, bus width and offset settings.
// Assumes writes are single-cycle strobes; values apply from the next edge.
module pag_cfg_regs
    import pag_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [1:0]            row_sel,
    input  logic                  row320,
    input  logic [2:0]            bpp_sel,
    input  logic [1:0]            bus_sel,
    input  logic [PAG_BASE_W-1:0] base,
    output pag_cfg_t              cfg_q
);

    // Purpose: load configuration on a write, defaults on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= PAG_CFG_RESET;
        end else if (we) begin
            cfg_q.row      <= row_sel;
            cfg_q.m320     <= row320;
            cfg_q.fmt.bpp  <= bpp_sel;
            cfg_q.fmt.bus  <= bus_sel;
            cfg_q.fmt.base <= base;
        end
    end

endmodule

// File: rtl/pag_row_stage.sv
// Module: pag_row_stage
// Accepts coordinates and forms the linear pixel index y*stride+x.
// Power-of-two strides use a fixed shift and finish in one cycle. The
// 320 stride (8 bpp only) adds y<<8 and y<<6, then x, over two more
// cycles while ready is low. A column not below the stride gives an
// out-of-range strobe. The formatting fields are snapshotted per request.
module pag_row_stage
    import pag_pkg::*;
#(
    parameter int X_W           = 11,
    parameter int Y_W           = 11,
    parameter int ROW_SHIFT_MIN = 8,
    parameter int NROW          = 4,
    parameter int ROW320        = 320,
    parameter int M320_HI       = 8,
    parameter int M320_LO       = 6,
    localparam int P_W          = X_W + Y_W
)(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [X_W-1:0] req_x,
    input  logic [Y_W-1:0] req_y,
    input  pag_cfg_t       cfg_i,
    output logic           req_ready,
    output logic           idx_valid,
    output logic           idx_oor,
    output logic [P_W-1:0] idx_q,
    output pag_fmt_cfg_t   fmt_snap
);

    typedef enum logic [1:0] {ST_IDLE, ST_ADD, ST_FIN} st_t;

    st_t            state;
    logic [P_W-1:0] acc;
    logic [X_W-1:0] x_hold;
    logic [Y_W-1:0] y_hold;

    logic [P_W-1:0] row_prod [NROW];
    logic [NROW-1:0] over_row;
    logic           accept;
    logic           use320;
    logic           oor;
    logic [P_W-1:0] shift_idx;

    // One shifted row product and one range test per power-of-two stride
    for (genvar g = 0; g < NROW; g++) begin : g_row
        assign row_prod[g] = P_W'(req_y) << (ROW_SHIFT_MIN + g);
        assign over_row[g] = (req_x >> (ROW_SHIFT_MIN + g)) != '0;
    end

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign use320    = cfg_i.m320 && (cfg_i.fmt.bpp == BPP_8);

    // Purpose: pick the range test for the active stride
    always_comb begin
        if (use320) oor = (req_x >= X_W'(ROW320));
        else        oor = over_row[cfg_i.row];
    end

    assign shift_idx = row_prod[cfg_i.row] + P_W'(req_x);

    // Purpose: request sequencing, index computation and result strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            acc       <= '0;
            x_hold    <= '0;
            y_hold    <= '0;
            idx_q     <= '0;
            idx_valid <= 1'b0;
            idx_oor   <= 1'b0;
            fmt_snap  <= PAG_CFG_RESET.fmt;
        end else begin
            idx_valid <= 1'b0;
            idx_oor   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        fmt_snap <= cfg_i.fmt;
                        if (oor) begin
                            idx_oor <= 1'b1;
                        end else if (use320) begin
                            acc    <= P_W'(req_y) << M320_HI;
                            x_hold <= req_x;
                            y_hold <= req_y;
                            state  <= ST_ADD;
                        end else begin
                            idx_q     <= shift_idx;
                            idx_valid <= 1'b1;
                        end
                    end
                end
                ST_ADD: begin
                    acc   <= acc + (P_W'(y_hold) << M320_LO);
                    state <= ST_FIN;
                end
                default: begin
                    idx_q     <= acc + P_W'(x_hold);
                    idx_valid <= 1'b1;
                    state     <= ST_IDLE;
                end
            endcase
        end
    end

    // R8: a result and an out-of-range strobe never coincide
    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(idx_valid && idx_oor));

    // R8: an out-of-range request strobes in the next cycle, without a result
    p_oor_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && oor) |=> (idx_oor && !idx_valid));

    // R2: a shift-mode request yields its result in the next cycle
    p_shift_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !use320 && !oor) |=> (idx_valid && req_ready));

    // R3: a 320-mode request blocks new requests and yields no result yet
    p_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && use320 && !oor) |=> (!req_ready && !idx_valid));

    // R3: the final add cycle delivers the result and reopens the port
    p_fin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIN) |=> (idx_valid && req_ready));

endmodule

// File: rtl/pag_addr_fmt.sv
// Module: pag_addr_fmt
// Scales the pixel index by the depth into a bit offset, then forms the
// byte address under the high-order offset, the starting byte lane and
// the bit position. Only the low LOW_W+3 bits of the bit offset are kept,
// which is exact for every field produced.
module pag_addr_fmt
    import pag_pkg::*;
#(
    parameter int P_W    = 22,
    parameter int ADDR_W = 32,
    localparam int LOW_W = ADDR_W - PAG_BASE_W,
    localparam int BIT_W = LOW_W + 3
)(
    input  logic [P_W-1:0]    idx,
    input  pag_fmt_cfg_t      fmt,
    output logic [ADDR_W-1:0] addr,
    output logic [1:0]        lane,
    output logic [2:0]        bitpos
);

    logic [BIT_W-1:0] idx_e;
    logic [BIT_W-1:0] bits;
    logic [LOW_W-1:0] low;

    assign idx_e = BIT_W'(idx);

    // Purpose: multiply the index by the depth using shifts only
    always_comb begin
        case (fmt.bpp)
            BPP_1:   bits = idx_e;
            BPP_2:   bits = idx_e << 1;
            BPP_4:   bits = idx_e << 2;
            BPP_16:  bits = idx_e << 4;
            BPP_24:  bits = (idx_e << 4) + (idx_e << 3);
            default: bits = idx_e << 3;
        endcase
    end

    assign low  = bits[BIT_W-1:3];
    assign addr = {fmt.base, low};

    // Purpose: starting byte lane for the selected bus width
    always_comb begin
        case (fmt.bus)
            BUS_8:   lane = 2'd0;
            BUS_16:  lane = {1'b0, low[0]};
            default: lane = low[1:0];
        endcase
    end

    // Purpose: bit position inside the byte for sub-byte depths
    always_comb begin
        case (fmt.bpp)
            BPP_1, BPP_2, BPP_4: bitpos = bits[2:0];
            default:             bitpos = 3'd0;
        endcase
    end

endmodule

// File: rtl/pix_addr_gen.sv
// Module: pix_addr_gen (top)
// Pixel coordinate to video memory byte address converter. Connects the
// configuration registers, the row/index stage and the address formatter.
// Assumes the offset width matches pag_pkg::PAG_BASE_W.
module pix_addr_gen
    import pag_pkg::*;
#(
    parameter int X_W    = 11,
    parameter int Y_W    = 11,
    parameter int ADDR_W = 32,
    localparam int P_W   = X_W + Y_W
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [1:0]            cfg_row_sel,
    input  logic                  cfg_row320,
    input  logic [2:0]            cfg_bpp_sel,
    input  logic [1:0]            cfg_bus_sel,
    input  logic [PAG_BASE_W-1:0] cfg_base,
    input  logic                  req_valid,
    input  logic [X_W-1:0]        req_x,
    input  logic [Y_W-1:0]        req_y,
    output logic                  req_ready,
    output logic                  out_valid,
    output logic                  out_oor,
    output logic [ADDR_W-1:0]     out_addr,
    output logic [1:0]            out_lane,
    output logic [2:0]            out_bit
);

    pag_cfg_t          cfg_q;
    pag_fmt_cfg_t      fmt_snap;
    logic [P_W-1:0]    idx_q;
    logic              idx_valid;
    logic [ADDR_W-1:0] addr_c;
    logic [1:0]        lane_c;
    logic [2:0]        bit_c;

    pag_cfg_regs u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .row_sel (cfg_row_sel),
        .row320  (cfg_row320),
        .bpp_sel (cfg_bpp_sel),
        .bus_sel (cfg_bus_sel),
        .base    (cfg_base),
        .cfg_q   (cfg_q)
    );

    pag_row_stage #(.X_W(X_W), .Y_W(Y_W)) u_row (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_x     (req_x),
        .req_y     (req_y),
        .cfg_i     (cfg_q),
        .req_ready (req_ready),
        .idx_valid (idx_valid),
        .idx_oor   (out_oor),
        .idx_q     (idx_q),
        .fmt_snap  (fmt_snap)
    );

    pag_addr_fmt #(.P_W(P_W), .ADDR_W(ADDR_W)) u_fmt (
        .idx    (idx_q),
        .fmt    (fmt_snap),
        .addr   (addr_c),
        .lane   (lane_c),
        .bitpos (bit_c)
    );

    assign out_valid = idx_valid;
    assign out_addr  = idx_valid ? addr_c : '0;
    assign out_lane  = idx_valid ? lane_c : 2'd0;
    assign out_bit   = idx_valid ? bit_c  : 3'd0;

    // R6: an 8-bit bus always reports lane 0
    p_lane8_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fmt_snap.bus == BUS_8) |-> (out_lane == 2'd0));

    // R7: byte-wide or wider depths report bit position 0
    p_bitwide_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fmt_snap.bpp >= BPP_8) |-> (out_bit == 3'd0));

    // R5: the high address bits carry the offset captured with the request
    p_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_addr[ADDR_W-1 -: PAG_BASE_W] == fmt_snap.base));

    // R1: the first cycle after reset has no strobe and the port is open
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_oor && req_ready));

endmodule

// File: tb/pix_addr_gen_tb.sv
module pix_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_row_sel;
    logic        cfg_row320;
    logic [2:0]  cfg_bpp_sel;
    logic [1:0]  cfg_bus_sel;
    logic [11:0] cfg_base;
    logic        req_valid;
    logic [10:0] req_x;
    logic [10:0] req_y;
    logic        req_ready;
    logic        out_valid;
    logic        out_oor;
    logic [31:0] out_addr;
    logic [1:0]  out_lane;
    logic [2:0]  out_bit;

    always #5 clk = ~clk;

    pix_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row_sel(cfg_row_sel),
        .cfg_row320(cfg_row320), .cfg_bpp_sel(cfg_bpp_sel),
        .cfg_bus_sel(cfg_bus_sel), .cfg_base(cfg_base),
        .req_valid(req_valid), .req_x(req_x), .req_y(req_y),
        .req_ready(req_ready), .out_valid(out_valid), .out_oor(out_oor),
        .out_addr(out_addr), .out_lane(out_lane), .out_bit(out_bit)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // model of the programmed configuration
    int m_row = 0, m_320 = 0, m_bpp = 3, m_bus = 2, m_base = 0;

    task automatic chk(string tag, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int bppv(int code);
        case (code)
            0: return 1;  1: return 2;  2: return 4;
            4: return 16; 5: return 24; default: return 8;
        endcase
    endfunction

    task automatic set_cfg(int row, int m320, int bpp, int bus, int base);
        @(negedge clk);
        cfg_we = 1'b1; cfg_row_sel = 2'(row); cfg_row320 = 1'(m320);
        cfg_bpp_sel = 3'(bpp); cfg_bus_sel = 2'(bus); cfg_base = 12'(base);
        m_row = row; m_320 = m320; m_bpp = bpp; m_bus = bus; m_base = base;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic expect_result(int x, int y, int row, int m320, int bpp,
                                 int bus, int base);
        bit   is320 = (m320 != 0) && (bpp == 3);
        int   stride = is320 ? 320 : (256 << row);
        longint idx  = longint'(y) * stride + x;
        longint bits = idx * bppv(bpp);
        longint byt  = bits >> 3;
        longint addr = (longint'(base) << 20) | (byt & 64'hFFFFF);
        int   lane = (bus == 0) ? 0 : (bus == 1) ? int'(byt & 1) : int'(byt & 3);
        int   bitp = (bppv(bpp) < 8) ? int'(bits & 7) : 0;
        string tg  = is320 ? "R3" : "R2";
        if (x >= stride) begin
            chk("R8 oor strobe", out_oor, 1);
            chk("R8 no valid", out_valid, 0);
        end else begin
            chk({tg, " valid"}, out_valid, 1);
            chk("R4 addr", out_addr, addr);
            chk("R5 base", out_addr[31:20], base);
            chk("R6 lane", out_lane, lane);
            chk("R7 bit", out_bit, bitp);
        end
    endtask

    task automatic run_req(int x, int y);
        bit is320 = (m_320 != 0) && (m_bpp == 3) && (x < 320);
        @(negedge clk);
        chk("R9 ready before req", req_ready, 1);
        req_valid = 1'b1; req_x = 11'(x); req_y = 11'(y);
        @(negedge clk);
        req_valid = 1'b0;
        if (is320) begin
            chk("R3 busy ready", req_ready, 0);
            chk("R3 busy valid", out_valid, 0);
            @(negedge clk);
            chk("R3 busy ready 2", req_ready, 0);
            chk("R3 busy valid 2", out_valid, 0);
            @(negedge clk);
        end
        expect_result(x, y, m_row, m_320, m_bpp, m_bus, m_base);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int xs[5];
        int ys[4];
        rst_n = 1'b0; cfg_we = 1'b0; cfg_row_sel = '0; cfg_row320 = 1'b0;
        cfg_bpp_sel = '0; cfg_bus_sel = '0; cfg_base = '0;
        req_valid = 1'b0; req_x = '0; req_y = '0;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", out_valid, 0);
        chk("R1 oor in reset", out_oor, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", req_ready, 1);
        chk("R1 valid after reset", out_valid, 0);
        // R1: defaults are stride 256, 8 bpp, 32-bit bus, offset 0
        run_req(5, 3);
        run_req(300, 0);

        // R2 R4 R5 R6 R7 R8: sweep shift strides, depths and bus widths
        ys = '{0, 1, 1234, 2047};
        for (int row = 0; row < 4; row++) begin
            for (int bpp = 0; bpp < 6; bpp++) begin
                for (int bus = 0; bus < 3; bus++) begin
                    int stride = 256 << row;
                    set_cfg(row, 0, bpp, bus, ((row * 7 + bpp * 3 + bus) * 273) & 12'hFFF);
                    xs = '{0, 1, stride - 1, (stride < 2048) ? stride : 1023, 2047};
                    for (int i = 0; i < 5; i++)
                        for (int j = 0; j < 4; j++)
                            run_req(xs[i], ys[j]);
                end
            end
        end

        // R3 R8: 320 stride at 8 bpp over every bus width
        xs = '{0, 1, 319, 320, 2047};
        ys = '{0, 1, 777, 2047};
        for (int bus = 0; bus < 3; bus++) begin
            set_cfg(0, 1, 3, bus, 12'hA5 + bus);
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 4; j++)
                    run_req(xs[i], ys[j]);
        end

        // R3: 320 enable at 16 bpp behaves as the power-of-two stride
        set_cfg(1, 1, 4, 2, 12'h3C);
        run_req(319, 9);
        run_req(400, 9);
        run_req(511, 2047);

        // R11: reserved depth codes scale as 8 bpp without the 320 stride
        for (int code = 6; code < 8; code++) begin
            set_cfg(0, 1, code, 1, 12'h7E1);
            run_req(100, 5);
            run_req(255, 2047);
            run_req(300, 1);
        end

        // R2: back-to-back requests in consecutive cycles
        set_cfg(0, 0, 3, 2, 12'h123);
        @(negedge clk);
        req_valid = 1'b1; req_x = 11'd1; req_y = 11'd1;
        @(negedge clk);
        chk("R2 ready stays high", req_ready, 1);
        expect_result(1, 1, 0, 0, 3, 2, 12'h123);
        req_x = 11'd2; req_y = 11'd0;
        @(negedge clk);
        req_valid = 1'b0;
        expect_result(2, 0, 0, 0, 3, 2, 12'h123);

        // R9: a request held during the 320 busy cycles is not taken
        set_cfg(0, 1, 3, 2, 12'h044);
        @(negedge clk);
        req_valid = 1'b1; req_x = 11'd10; req_y = 11'd2;
        @(negedge clk);
        req_x = 11'd50;
        chk("R9 busy ready", req_ready, 0);
        @(negedge clk);
        chk("R9 busy no result", out_valid, 0);
        @(negedge clk);
        req_valid = 1'b0;
        expect_result(10, 2, 0, 1, 3, 2, 12'h044);
        @(negedge clk);
        chk("R9 single result", out_valid, 0);
        chk("R9 no oor", out_oor, 0);
        chk("R9 ready again", req_ready, 1);

        // R10: write and request at the same edge; request uses old settings
        @(negedge clk);
        cfg_we = 1'b1; cfg_row_sel = 2'd1; cfg_row320 = 1'b0;
        cfg_bpp_sel = 3'd4; cfg_bus_sel = 2'd1; cfg_base = 12'hABC;
        req_valid = 1'b1; req_x = 11'd3; req_y = 11'd2;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        chk("R10 old 320 path busy", req_ready, 0);
        @(negedge clk);
        @(negedge clk);
        expect_result(3, 2, 0, 1, 3, 2, 12'h044);
        m_row = 1; m_320 = 0; m_bpp = 4; m_bus = 1; m_base = 12'hABC;
        // R10: the following request sees the new settings
        run_req(3, 2);
        run_req(600, 2);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule